// File: doc/BRIEF.md
# Event Counter Bank with Hardware Run Control

This block holds a small bank of wide event counters. A filter stage upstream presents a per-cycle increment for each counter, and each counter adds its increment only while two conditions both hold: its bit in a central run-enable register is set, and the run flag inside its own event-select word is set. Software programs and reads everything through a simple single-cycle register port.

The run flag of each counter can also be driven by hardware. Two chip-level trigger pulses (start and stop) set or clear it, and so can the overflow of another counter chosen per counter. Counting can therefore be limited to a window between two trigger points, or made conditional on a peer counter having seen a preset number of events. Overflow is flagged when a counter's top bit rises. It lands in a sticky status register that software clears by writing ones. A level interrupt is driven while any sticky bit whose interrupt enable is set remains set.

Top module: `pmc_bank`

## Requirements
- R1: After reset all counters, event-select words, link words, the run-enable register, the sticky overflow register and the interrupt-enable register read as zero, and `irq` is low.
- R2: Counter i adds the unsigned value of `evt_inc` lane i (bits `[i*INC_W +: INC_W]`) at each clock edge where run-enable bit i and the run flag of counter i are both set; otherwise it holds its value.
- R3: Address map: 0x00 run enable, 0x01 sticky overflow, 0x02 interrupt enable (bit i = counter i); counter i uses 0x40+4i for its value, 0x41+4i for its event-select word and 0x42+4i for its link word. The event-select word keeps the event code in bits [15:0], the event type in bits [19:16], event-info in bits [62:20] and the run flag in bit 63, and reads back as written. The link word reads back only bits [3:0] and [11:8]. Unmapped addresses read zero.
- R4: Writing the run-enable register freezes or releases every counter in the same cycle, whatever its run flag holds.
- R5: The sticky overflow bit of counter i is set at the edge where an increment moves the counter's top bit from 0 to 1. A wrap from all ones (top bit 1 to 0) and a software write of the counter do not set it.
- R6: A sticky bit stays set until a write to 0x01 with a 1 in its position; a 0 leaves it set. If an overflow and a clear hit the same bit in one cycle, the bit ends up set.
- R7: `irq` is high exactly while some sticky bit i and interrupt-enable bit i are both set.
- R8: Link bit 0 makes `trig_start` set the run flag and link bit 1 makes `trig_stop` clear it, both at the next edge. If both requests apply in one cycle, the flag ends up clear.
- R9: Link bit 2 sets and link bit 3 clears the run flag at the edge where the counter whose index is in link bits [11:8] overflows (as in R5). Indices at or above the counter count never match.
- R10: A software write of the event-select word sets the run flag to bit 63 of the written data, overriding any trigger or overflow request in the same cycle.
- R11: A software write of a counter value loads that value and discards the increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address for read and write |
| reg_wr | input | 1 | Write strobe for `reg_addr` |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| evt_inc | input | NUM_CTR*INC_W | Per-counter increment lanes from the filter stage |
| trig_start | input | 1 | Start trigger pulse |
| trig_stop | input | 1 | Stop trigger pulse |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a peer overflow that starts or stops another counter in the exact cycle where the top bit rises. Reaching that bit by counting would take on the order of 2^63 events. The stimulus therefore loads counters through the register port to a few counts below the threshold and then applies a single increment. The random phase keeps writing near-threshold values, random link words and random trigger pulses, so that overflows, software clears and trigger requests meet in the same cycle. A bench model compares the readback and `irq` after every cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int WORD_W  = 64;
   localparam int ADDR_W  = 8;
   localparam int RUN_BIT = 63;
   localparam int PEER_W  = 4;

   localparam logic [ADDR_W-1:0] A_RUN_EN = 8'h00;
   localparam logic [ADDR_W-1:0] A_OVF    = 8'h01;
   localparam logic [ADDR_W-1:0] A_IRQ_EN = 8'h02;
   localparam logic [1:0]        BANK_REGION = 2'b01;

   typedef enum logic [1:0] {
      SUB_COUNT  = 2'd0,
      SUB_SELECT = 2'd1,
      SUB_LINK   = 2'd2,
      SUB_NONE   = 2'd3
   } sub_e;

   typedef struct packed {
      logic [PEER_W-1:0] peer;
      logic              stop_on_ovf;
      logic              start_on_ovf;
      logic              stop_on_trig;
      logic              start_on_trig;
   } link_t;

   function automatic link_t link_from_word(input logic [WORD_W-1:0] w);
      link_t l;
      l.start_on_trig = w[0];
      l.stop_on_trig  = w[1];
      l.start_on_ovf  = w[2];
      l.stop_on_ovf   = w[3];
      l.peer          = w[11:8];
      return l;
   endfunction

   function automatic logic [WORD_W-1:0] link_to_word(input link_t l);
      logic [WORD_W-1:0] w;
      w       = '0;
      w[0]    = l.start_on_trig;
      w[1]    = l.stop_on_trig;
      w[2]    = l.start_on_ovf;
      w[3]    = l.stop_on_ovf;
      w[11:8] = l.peer;
      return w;
   endfunction
endpackage

// File: rtl/pmc_addr_dec.sv
module pmc_addr_dec
   import pmc_pkg::*;
#(
   parameter int NUM_CTR = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              run_en_we,
   output logic              ovf_we,
   output logic              irq_en_we,
   output logic [NUM_CTR-1:0] cnt_we,
   output logic [NUM_CTR-1:0] sel_we,
   output logic [NUM_CTR-1:0] lnk_we,
   output logic              in_bank,
   output logic [3:0]        slot,
   output sub_e              sub
);
   localparam logic [4:0] NUM_C5 = 5'(NUM_CTR);

   assign slot    = addr[5:2];
   assign sub     = sub_e'(addr[1:0]);
   assign in_bank = (addr[7:6] == BANK_REGION) && ({1'b0, slot} < NUM_C5);

   assign run_en_we = wr && (addr == A_RUN_EN);
   assign ovf_we    = wr && (addr == A_OVF);
   assign irq_en_we = wr && (addr == A_IRQ_EN);

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
      logic hit;
      assign hit       = wr && in_bank && (slot == 4'(i));
      assign cnt_we[i] = hit && (sub == SUB_COUNT);
      assign sel_we[i] = hit && (sub == SUB_SELECT);
      assign lnk_we[i] = hit && (sub == SUB_LINK);
   end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
   parameter int CTR_W = 64,
   parameter int INC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             sw_wr,
   input  logic [CTR_W-1:0] sw_val,
   input  logic [INC_W-1:0] inc,
   output logic [CTR_W-1:0] value,
   output logic             ovf_pulse
);
   logic [CTR_W-1:0] sum;

   if (INC_W == 1) begin : g_unit
      assign sum = value + {{(CTR_W-1){1'b0}}, inc[0]};
   end else begin : g_multi
      assign sum = value + {{(CTR_W-INC_W){1'b0}}, inc};
   end

   assign ovf_pulse = run && !sw_wr && !value[CTR_W-1] && sum[CTR_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n)      value <= '0;
      else if (sw_wr)  value <= sw_val;
      else if (run)    value <= sum;
   end

   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !sw_wr) |=> $stable(value));                              // R2
   AST_CTR_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr |=> (value == $past(sw_val)));                               // R11
   AST_OVF_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> value[CTR_W-1]);                                     // R5
   AST_OVF_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> !value[CTR_W-1]);                                    // R5
endmodule

// File: rtl/pmc_run_ctl.sv
module pmc_run_ctl
   import pmc_pkg::*;
#(
   parameter int NUM_CTR = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_we,
   input  logic               lnk_we,
   input  logic [WORD_W-1:0]  wdata,
   input  logic               trig_start,
   input  logic               trig_stop,
   input  logic [NUM_CTR-1:0] peer_ovf,
   output logic [WORD_W-1:0]  sel_word,
   output logic [WORD_W-1:0]  lnk_word,
   output logic               active
);
   link_t             lnk_q;
   logic [RUN_BIT-1:0] body_q;
   logic              act_q;
   logic              peer_hit;
   logic              start_req;
   logic              stop_req;

   always_comb begin
      peer_hit = 1'b0;
      for (int k = 0; k < NUM_CTR; k++) begin
         if (lnk_q.peer == PEER_W'(k)) peer_hit = peer_ovf[k];
      end
   end

   assign start_req = (lnk_q.start_on_trig && trig_start) || (lnk_q.start_on_ovf && peer_hit);
   assign stop_req  = (lnk_q.stop_on_trig  && trig_stop)  || (lnk_q.stop_on_ovf  && peer_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         body_q <= '0;
      end else if (sel_we) begin
         act_q  <= wdata[RUN_BIT];
         body_q <= wdata[RUN_BIT-1:0];
      end else if (stop_req) begin
         act_q  <= 1'b0;
      end else if (start_req) begin
         act_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      lnk_q <= '0;
      else if (lnk_we) lnk_q <= link_from_word(wdata);
   end

   assign sel_word = {act_q, body_q};
   assign lnk_word = link_to_word(lnk_q);
   assign active   = act_q;

   AST_SW_SEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> (active == $past(wdata[RUN_BIT])));                     // R10
   AST_TRIG_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_we && lnk_q.stop_on_trig && trig_stop) |=> !active);         // R8
   AST_PEER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_we && !stop_req && lnk_q.start_on_ovf && peer_hit) |=> active); // R9
   AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_we && !start_req && !stop_req) |=> $stable(active));         // R8
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
   import pmc_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 64,
   parameter int INC_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [7:0]               reg_addr,
   input  logic                     reg_wr,
   input  logic [63:0]              reg_wdata,
   output logic [63:0]              reg_rdata,
   input  logic [NUM_CTR*INC_W-1:0] evt_inc,
   input  logic                     trig_start,
   input  logic                     trig_stop,
   output logic                     irq
);
   if (NUM_CTR < 2 || NUM_CTR > 16) begin : g_bad_num
      $error("pmc_bank: NUM_CTR must lie in 2..16");
   end
   if (CTR_W < 8 || CTR_W > WORD_W) begin : g_bad_width
      $error("pmc_bank: CTR_W must lie in 8..64");
   end
   if (INC_W < 1 || INC_W >= CTR_W) begin : g_bad_inc
      $error("pmc_bank: INC_W must lie in 1..CTR_W-1");
   end

   logic               run_en_we, ovf_we, irq_en_we, in_bank;
   logic [NUM_CTR-1:0] cnt_we, sel_we, lnk_we;
   logic [3:0]         slot;
   sub_e               sub;

   logic [NUM_CTR-1:0] run_en_q, ovf_q, irq_en_q;
   logic [NUM_CTR-1:0] ovf_pulse, active, run;
   logic [NUM_CTR-1:0] ovf_clr;
   logic [CTR_W-1:0]   cnt_val  [NUM_CTR];
   logic [WORD_W-1:0]  sel_word [NUM_CTR];
   logic [WORD_W-1:0]  lnk_word [NUM_CTR];

   pmc_addr_dec #(.NUM_CTR(NUM_CTR)) u_dec (
      .addr      (reg_addr),
      .wr        (reg_wr),
      .run_en_we (run_en_we),
      .ovf_we    (ovf_we),
      .irq_en_we (irq_en_we),
      .cnt_we    (cnt_we),
      .sel_we    (sel_we),
      .lnk_we    (lnk_we),
      .in_bank   (in_bank),
      .slot      (slot),
      .sub       (sub)
   );

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      assign run[i] = run_en_q[i] && active[i];

      pmc_counter #(.CTR_W(CTR_W), .INC_W(INC_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (run[i]),
         .sw_wr     (cnt_we[i]),
         .sw_val    (reg_wdata[CTR_W-1:0]),
         .inc       (evt_inc[i*INC_W +: INC_W]),
         .value     (cnt_val[i]),
         .ovf_pulse (ovf_pulse[i])
      );

      pmc_run_ctl #(.NUM_CTR(NUM_CTR)) u_run (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel_we     (sel_we[i]),
         .lnk_we     (lnk_we[i]),
         .wdata      (reg_wdata),
         .trig_start (trig_start),
         .trig_stop  (trig_stop),
         .peer_ovf   (ovf_pulse),
         .sel_word   (sel_word[i]),
         .lnk_word   (lnk_word[i]),
         .active     (active[i])
      );

      AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf_q[i] && !ovf_clr[i]) |=> ovf_q[i]);                        // R6
      AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_pulse[i] |=> ovf_q[i]);                                     // R6
      AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf_pulse[i] && irq_en_q[i] && !irq_en_we) |=> irq);           // R7
   end

   assign ovf_clr = ovf_we ? reg_wdata[NUM_CTR-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_en_q <= '0;
         irq_en_q <= '0;
         ovf_q    <= '0;
      end else begin
         if (run_en_we) run_en_q <= reg_wdata[NUM_CTR-1:0];
         if (irq_en_we) irq_en_q <= reg_wdata[NUM_CTR-1:0];
         ovf_q <= (ovf_q & ~ovf_clr) | ovf_pulse;
      end
   end

   assign irq = |(ovf_q & irq_en_q);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_RUN_EN) begin
         reg_rdata[NUM_CTR-1:0] = run_en_q;
      end else if (reg_addr == A_OVF) begin
         reg_rdata[NUM_CTR-1:0] = ovf_q;
      end else if (reg_addr == A_IRQ_EN) begin
         reg_rdata[NUM_CTR-1:0] = irq_en_q;
      end else if (in_bank) begin
         for (int k = 0; k < NUM_CTR; k++) begin
            if (slot == 4'(k)) begin
               case (sub)
                  SUB_COUNT:  reg_rdata[CTR_W-1:0] = cnt_val[k];
                  SUB_SELECT: reg_rdata = sel_word[k];
                  SUB_LINK:   reg_rdata = lnk_word[k];
                  default:    reg_rdata = '0;
               endcase
            end
         end
      end
   end

   AST_FROZEN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en_q == '0) |-> (ovf_pulse == '0));                           // R4
endmodule

// File: tb/pmc_bank_tb.sv
module pmc_bank_tb;
   localparam int N  = 4;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [63:0]   reg_wdata = '0;
   logic [63:0]   reg_rdata;
   logic [N*IW-1:0] evt_inc = '0;
   logic          trig_start = 1'b0;
   logic          trig_stop = 1'b0;
   logic          irq;

   int total = 0;
   int bad   = 0;

   logic [63:0] m_cnt [N];
   logic [63:0] m_sel [N];
   logic [15:0] m_lnk [N];
   logic [N-1:0] m_en, m_ovf, m_ie;
   logic [63:0] last_rd;
   logic        last_irq;

   always #10 clk = ~clk;

   pmc_bank #(.NUM_CTR(N), .CTR_W(64), .INC_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_inc(evt_inc),
      .trig_start(trig_start), .trig_stop(trig_stop), .irq(irq));

   function automatic logic [7:0] a_cnt(input int i); return 8'h40 + 8'(i * 4);     endfunction
   function automatic logic [7:0] a_sel(input int i); return 8'h41 + 8'(i * 4);     endfunction
   function automatic logic [7:0] a_lnk(input int i); return 8'h42 + 8'(i * 4);     endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] model_read(input logic [7:0] a);
      logic [63:0] r;
      r = '0;
      if (a == 8'h00) r = 64'(m_en);
      else if (a == 8'h01) r = 64'(m_ovf);
      else if (a == 8'h02) r = 64'(m_ie);
      else if (a[7:6] == 2'b01 && a[5:2] < N) begin
         case (a[1:0])
            2'd0: r = m_cnt[a[5:2]];
            2'd1: r = m_sel[a[5:2]];
            2'd2: r = 64'(m_lnk[a[5:2]]);
            default: r = '0;
         endcase
      end
      return r;
   endfunction

   task automatic model_step(input logic [7:0] a, input logic w, input logic [63:0] d,
                             input logic [N*IW-1:0] inc, input logic ts, input logic tp);
      logic [N-1:0] p;
      logic [N-1:0] run;
      logic [63:0]  nx [N];
      for (int i = 0; i < N; i++) begin
         logic [IW-1:0] li;
         li     = inc[i*IW +: IW];
         run[i] = m_en[i] && m_sel[i][63];
         nx[i]  = m_cnt[i] + 64'(li);
         p[i]   = run[i] && !(w && a == a_cnt(i)) && !m_cnt[i][63] && nx[i][63];
      end
      for (int i = 0; i < N; i++) begin
         logic [3:0] src;
         logic ph, stp, sta;
         src = m_lnk[i][11:8];
         ph  = (src < N) ? p[src] : 1'b0;
         stp = (m_lnk[i][1] && tp) || (m_lnk[i][3] && ph);
         sta = (m_lnk[i][0] && ts) || (m_lnk[i][2] && ph);
         if (w && a == a_sel(i)) m_sel[i] = d;
         else if (stp)           m_sel[i][63] = 1'b0;
         else if (sta)           m_sel[i][63] = 1'b1;
         if (w && a == a_lnk(i)) m_lnk[i] = d[15:0] & 16'h0F0F;
         if (w && a == a_cnt(i)) m_cnt[i] = d;
         else if (run[i])        m_cnt[i] = nx[i];
      end
      m_ovf = (m_ovf & ~((w && a == 8'h01) ? d[N-1:0] : '0)) | p;
      if (w && a == 8'h00) m_en = d[N-1:0];
      if (w && a == 8'h02) m_ie = d[N-1:0];
   endtask

   // One clock: drive at negedge, compare readback and irq with the model, step model.
   task automatic cyc(input logic [7:0] a, input logic w, input logic [63:0] d,
                      input logic [N*IW-1:0] inc, input logic ts, input logic tp, input string tag);
      reg_addr = a; reg_wr = w; reg_wdata = d; evt_inc = inc;
      trig_start = ts; trig_stop = tp;
      #1;
      last_rd  = reg_rdata;
      last_irq = irq;
      chk({tag, " model readback"}, reg_rdata, model_read(a));
      chk("R7 model irq", {63'd0, irq}, {63'd0, |(m_ovf & m_ie)});
      model_step(a, w, d, inc, ts, tp);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d, input string tag);
      cyc(a, 1'b1, d, '0, 1'b0, 1'b0, tag);
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [63:0] exp, input string tag);
      cyc(a, 1'b0, '0, '0, 1'b0, 1'b0, tag);
      chk(tag, last_rd, exp);
   endtask

   task automatic run_n(input logic [N*IW-1:0] inc, input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(8'h03, 1'b0, '0, inc, 1'b0, 1'b0, tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_sel[i] = '0; m_lnk[i] = '0; end
      m_en = '0; m_ovf = '0; m_ie = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(8'h00, 64'd0, "R1 run enable");
      rd_chk(8'h01, 64'd0, "R1 sticky");
      rd_chk(a_cnt(0), 64'd0, "R1 counter0");
      rd_chk(a_sel(2), 64'd0, "R1 select2");
      chk("R1 irq", {63'd0, last_irq}, 64'd0);

      // R3 field layout and link masking
      wr(a_sel(1), 64'h7ABC_DEF0_1234_5A5A, "R3");
      rd_chk(a_sel(1), 64'h7ABC_DEF0_1234_5A5A, "R3 select readback");
      wr(a_lnk(1), 64'hFFFF_FFFF_FFFF_FFFF, "R3");
      rd_chk(a_lnk(1), 64'h0000_0000_0000_0F0F, "R3 link mask");
      wr(a_lnk(1), 64'd0, "R3");
      rd_chk(8'h37, 64'd0, "R3 unmapped");

      // R2 counting gated by enable and run flag
      wr(8'h00, 64'hF, "R4");
      wr(a_sel(0), 64'h8000_0000_0000_0001, "R2");
      run_n(16'h0073, 5, "R2");
      rd_chk(a_cnt(0), 64'd15, "R2 active counter");
      rd_chk(a_cnt(1), 64'd0, "R2 inactive counter");

      // R4 central freeze
      wr(8'h00, 64'h0, "R4");
      run_n(16'h0003, 4, "R4");
      rd_chk(a_cnt(0), 64'd15, "R4 frozen");
      wr(8'h00, 64'hF, "R4");

      // R11 software write beats increment
      cyc(a_cnt(0), 1'b1, 64'd100, 16'h0005, 1'b0, 1'b0, "R11");
      rd_chk(a_cnt(0), 64'd100, "R11 write wins");

      // R5 overflow, R7 interrupt
      wr(a_cnt(0), 64'h7FFF_FFFF_FFFF_FFFE, "R5");
      run_n(16'h0003, 1, "R5");
      rd_chk(a_cnt(0), 64'h8000_0000_0000_0001, "R5 crossed value");
      rd_chk(8'h01, 64'h1, "R5 sticky set");
      chk("R7 irq masked", {63'd0, last_irq}, 64'd0);
      wr(8'h02, 64'h1, "R7");
      rd_chk(8'h01, 64'h1, "R7");
      chk("R7 irq raised", {63'd0, last_irq}, 64'd1);

      // R6 clear semantics
      wr(8'h01, 64'h0, "R6");
      rd_chk(8'h01, 64'h1, "R6 zero write keeps");
      wr(8'h01, 64'h1, "R6");
      rd_chk(8'h01, 64'h0, "R6 one write clears");
      chk("R7 irq dropped", {63'd0, last_irq}, 64'd0);
      wr(a_cnt(0), 64'h7FFF_FFFF_FFFF_FFFF, "R6");
      cyc(8'h01, 1'b1, 64'h1, 16'h0001, 1'b0, 1'b0, "R6");
      rd_chk(8'h01, 64'h1, "R6 set beats clear");
      wr(8'h01, 64'hF, "R6");

      // R5 wrap and software write do not flag
      wr(a_sel(1), 64'h8000_0000_0000_0000, "R5");
      wr(a_cnt(1), 64'hFFFF_FFFF_FFFF_FFFF, "R5");
      run_n(16'h0020, 1, "R5");
      rd_chk(a_cnt(1), 64'd1, "R5 wrap value");
      wr(a_cnt(1), 64'h8000_0000_0000_0000, "R5");
      rd_chk(8'h01, 64'h0, "R5 no flag on wrap or write");
      wr(a_sel(1), 64'h0, "R5");

      // R8 trigger window
      wr(a_lnk(2), 64'h3, "R8");
      rd_chk(a_sel(2), 64'h0, "R8 idle");
      cyc(8'h03, 1'b0, '0, '0, 1'b1, 1'b0, "R8");
      rd_chk(a_sel(2), 64'h8000_0000_0000_0000, "R8 start");
      run_n(16'h0100, 4, "R8");
      cyc(8'h03, 1'b0, '0, '0, 1'b0, 1'b1, "R8");
      run_n(16'h0100, 3, "R8");
      rd_chk(a_cnt(2), 64'd4, "R8 window count");
      cyc(8'h03, 1'b0, '0, '0, 1'b1, 1'b1, "R8");
      rd_chk(a_sel(2), 64'h0, "R8 stop wins");

      // R10 software write beats trigger
      cyc(a_sel(2), 1'b1, 64'h0000_0000_0000_0042, '0, 1'b1, 1'b0, "R10");
      rd_chk(a_sel(2), 64'h0000_0000_0000_0042, "R10 write wins");

      // R9 peer overflow start then stop
      wr(a_lnk(3), 64'h0004, "R9");
      wr(a_cnt(0), 64'h7FFF_FFFF_FFFF_FFFF, "R9");
      cyc(8'h03, 1'b0, '0, 16'h5001, 1'b0, 1'b0, "R9");
      rd_chk(a_sel(3), 64'h8000_0000_0000_0000, "R9 started by peer");
      rd_chk(a_cnt(3), 64'd0, "R9 no count in trigger cycle");
      run_n(16'h5000, 2, "R9");
      rd_chk(a_cnt(3), 64'd10, "R9 counting after start");
      wr(a_lnk(3), 64'h0008, "R9");
      wr(a_cnt(0), 64'h7FFF_FFFF_FFFF_FFFF, "R9");
      cyc(8'h03, 1'b0, '0, 16'h0001, 1'b0, 1'b0, "R9");
      rd_chk(a_sel(3), 64'h0, "R9 stopped by peer");

      // Random phase against the model
      for (int k = 0; k < 4000; k++) begin
         logic [7:0]  a;
         logic        w;
         logic [63:0] d;
         int          r;
         r = $urandom % 20;
         if (r < 3)       a = 8'(r);
         else if (r < 19) a = 8'h40 + 8'(r - 3);
         else             a = 8'($urandom);
         w = ($urandom % 6) == 0;
         d = {$urandom, $urandom};
         if (a[7:6] == 2'b01 && a[1:0] == 2'd0 && $urandom % 2 == 0)
            d = 64'h7FFF_FFFF_FFFF_FF00 | 64'($urandom % 256);
         if (a == 8'h00 && $urandom % 4 != 0) d = 64'hF;
         cyc(a, w, d, 16'($urandom), ($urandom % 12) == 0, ($urandom % 12) == 0,
             "R2 R3 R5 R8 R9 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule